// File: doc/BRIEF.md
# Serial Converter Digital Port Model

This block is a synthesizable stand-in for the digital side of a 12-bit serial sampling converter with a two-input multiplexer. It lets a host controller under test be exercised without analog parts. The host drives a conversion strobe, a shift clock and a serial data line. All three are asynchronous to the block's fast system clock, so the block samples and synchronizes them. Four parallel code words stand in for the analog result, one for each input pairing the multiplexer can select. At the end of a conversion the block loads the word for the active pairing and shifts it out MSB first on falling shift-clock edges. While the port is enabled, the host supplies a two-bit multiplexer word that takes effect at the next conversion.

A four-state controller sequences the port.
- `ST_IDLE` is the state after reset.
- `ST_CONV` counts out the conversion interval.
- `ST_SLEEP` holds the port idle while the strobe stays high after the conversion is done.
- `ST_SHIFT` is the transfer state, with the output enabled.

The transitions are:
- START: a strobe rise moves any state to `ST_CONV`. A rise in `ST_CONV` also restarts the count.
- DONE_HIGH: `ST_CONV` goes to `ST_SLEEP` when the count ends with the strobe high.
- DONE_LOW: `ST_CONV` goes to `ST_SHIFT` when the count ends with the strobe already low.
- WAKE: `ST_SLEEP` goes to `ST_SHIFT` on a strobe fall.

A strobe rise from `ST_SHIFT` is the same START transition. The result word is loaded on both DONE_LOW and WAKE.

Top module: `sadc_port_model`

## Requirements
- R1: After reset, every output is 0: `sdo_oe_o`, `sdo_o`, `converting_o`, `sleep_o` and `proto_err_o`. The stored multiplexer word is 2'b10.
- R2: `sdo_oe_o` is 0 in `ST_IDLE`, `ST_CONV` and `ST_SLEEP`, and `sdo_o` reads 0 whenever `sdo_oe_o` is 0.
- R3: A strobe rise makes `converting_o` 1 after the third following clock edge. It then stays 1 for exactly CONV_CYCLES clocks. After that the block enters sleep (`sleep_o`=1) if the strobe is high, or enables the output if the strobe is already low.
- R4: From sleep, a strobe fall sets `sdo_oe_o` to 1 after the third clock edge. The result MSB is already present on `sdo_o` at that point.
- R5: Each falling shift-clock edge while enabled presents the next lower result bit on `sdo_o`.
- R6: After the 12 result bits, further falling shift-clock edges keep `sdo_o` at 0 for as long as they continue.
- R7: In each transfer, the first two `sdi_i` values sampled on rising shift-clock edges form the multiplexer word, in the order {single/differential, odd/sign}. Later bits are ignored. The word selects the code used by the next conversion.
- R8: The multiplexer word selects the code word as follows: 2'b10 selects `code_se0_i`, 2'b11 selects `code_se1_i`, 2'b00 selects `code_d01_i` (input 0 positive, input 1 negative), and 2'b01 selects `code_d10_i`. Codes are straight binary, where all zeros is a zero difference and all ones is full scale.
- R9: `proto_err_o` is set by a strobe rise during `ST_CONV`, which also restarts the conversion. It is also set by a rise after 1 to 11 falling shift-clock edges of a transfer. A rise after 0 edges or after 12 or more edges leaves it clear. It stays set until reset.
- R10: Shift-clock edges while the output is disabled neither shift the result nor change `sdo_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Conversion strobe (asynchronous) |
| sck_i | input | 1 | Shift clock from the host (asynchronous) |
| sdi_i | input | 1 | Serial multiplexer word from the host |
| code_se0_i | input | DATA_W | Code for input 0 against ground |
| code_se1_i | input | DATA_W | Code for input 1 against ground |
| code_d01_i | input | DATA_W | Code for input 0 positive, input 1 negative |
| code_d10_i | input | DATA_W | Code for input 1 positive, input 0 negative |
| sdo_o | output | 1 | Serial result data |
| sdo_oe_o | output | 1 | Output enable, where 0 stands for high impedance |
| converting_o | output | 1 | Conversion in progress |
| sleep_o | output | 1 | Conversion done with the strobe still high |
| proto_err_o | output | 1 | Sticky strobe-timing error |

## Verification
Every pairing gets a distinct code word: 12'hA5C, 12'h3E1, a full-scale 12'hFFF and 12'h801. Because of this, a wrong pairing, a lost bit or a wrong bit order each changes the word read back. The multiplexer words are sent in a chain (11, 00, 01, 10), with the ignored later bits set to the opposite values. This separates the two-bit latch from a latch of later bits, and shows the one-conversion delay. Strobe rises are tried after a full read, after no read and after a partial read, and also inside the conversion interval, to separate the error cases. Shift pulses during sleep, an early strobe fall, and a 16-bit read that checks the zero tail cover the remaining paths.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_SHIFT = 2'd3
    } sadc_state_e;

    // multiplexer word {single/differential, odd/sign}
    typedef enum logic [1:0] {
        MUX_DIFF_01 = 2'b00,
        MUX_DIFF_10 = 2'b01,
        MUX_SE_0    = 2'b10,
        MUX_SE_1    = 2'b11
    } sadc_mux_e;

    localparam int SADC_NUM_SEL = 4;

endpackage

// File: rtl/sadc_edge_sync.sv
module sadc_edge_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-1:0], async_i[b]};
                end
            end

            assign lvl_o[b]  = chain[STAGES-1];
            assign rise_o[b] = chain[STAGES-1] & ~chain[STAGES];
            assign fall_o[b] = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/sadc_fsm.sv
module sadc_fsm
    import sadc_pkg::*;
#(
    parameter int CONV_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_lvl_i,
    input  logic conv_rise_i,
    input  logic conv_fall_i,
    input  logic xfer_partial_i,
    output logic start_o,
    output logic load_o,
    output logic in_shift_o,
    output logic converting_o,
    output logic sleep_o,
    output logic err_o
);

    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    sadc_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          count_done;

    assign count_done = (cnt_q == LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (conv_rise_i) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (conv_rise_i)     state_d = ST_CONV;
                else if (count_done) state_d = conv_lvl_i ? ST_SLEEP : ST_SHIFT;
            end
            ST_SLEEP: begin
                if (conv_rise_i)      state_d = ST_CONV;
                else if (conv_fall_i) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (conv_rise_i) state_d = ST_CONV;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // conversion interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (conv_rise_i) begin
            cnt_q <= '0;
        end else if (state_q == ST_CONV && !count_done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // sticky protocol error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_o <= 1'b0;
        end else if (conv_rise_i &&
                     (state_q == ST_CONV || (state_q == ST_SHIFT && xfer_partial_i))) begin
            err_o <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        start_o      = conv_rise_i;
        load_o       = (state_q != ST_SHIFT) && (state_d == ST_SHIFT);
        in_shift_o   = (state_q == ST_SHIFT);
        converting_o = (state_q == ST_CONV);
        sleep_o      = (state_q == ST_SLEEP);
    end

endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
    import sadc_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    input  logic                                 load_i,
    input  logic                                 in_shift_i,
    input  logic                                 sck_rise_i,
    input  logic                                 sck_fall_i,
    input  logic                                 sdi_lvl_i,
    input  logic [SADC_NUM_SEL-1:0][DATA_W-1:0]  codes_i,
    output logic                                 bit_o,
    output logic                                 partial_o
);

    localparam int FCW = $clog2(DATA_W + 1);
    localparam logic [FCW-1:0] FULL = FCW'(DATA_W);

    sadc_mux_e        next_sel_q, act_sel_q;
    logic [DATA_W-1:0] shreg_q;
    logic [FCW-1:0]   falls_q;
    logic [1:0]       rx_cnt_q;
    logic             rx_first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_sel_q <= MUX_SE_0;
            act_sel_q  <= MUX_SE_0;
            shreg_q    <= '0;
            falls_q    <= '0;
            rx_cnt_q   <= '0;
            rx_first_q <= 1'b0;
        end else if (start_i) begin
            act_sel_q <= next_sel_q;
            falls_q   <= '0;
        end else if (load_i) begin
            shreg_q  <= codes_i[act_sel_q];
            falls_q  <= '0;
            rx_cnt_q <= '0;
        end else if (in_shift_i) begin
            if (sck_fall_i) begin
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
                if (falls_q != FULL) falls_q <= falls_q + 1'b1;
            end
            if (sck_rise_i && rx_cnt_q != 2'd2) begin
                rx_cnt_q <= rx_cnt_q + 1'b1;
                if (rx_cnt_q == 2'd0) rx_first_q <= sdi_lvl_i;
                else                  next_sel_q <= sadc_mux_e'({rx_first_q, sdi_lvl_i});
            end
        end
    end

    assign bit_o     = shreg_q[DATA_W-1];
    assign partial_o = (falls_q != '0) && (falls_q != FULL);

endmodule

// File: rtl/sadc_port_model.sv
module sadc_port_model
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] code_se0_i,
    input  logic [DATA_W-1:0] code_se1_i,
    input  logic [DATA_W-1:0] code_d01_i,
    input  logic [DATA_W-1:0] code_d10_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              converting_o,
    output logic              sleep_o,
    output logic              proto_err_o
);

    localparam int PIN_CONV = 2;
    localparam int PIN_SCK  = 1;
    localparam int PIN_SDI  = 0;

    logic [2:0] lvl, rise, fall;
    logic start, load, in_shift, partial, shift_bit;
    logic [SADC_NUM_SEL-1:0][DATA_W-1:0] codes;

    always_comb begin
        codes[MUX_DIFF_01] = code_d01_i;
        codes[MUX_DIFF_10] = code_d10_i;
        codes[MUX_SE_0]    = code_se0_i;
        codes[MUX_SE_1]    = code_se1_i;
    end

    sadc_edge_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({conv_i, sck_i, sdi_i}),
        .lvl_o   (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    sadc_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .conv_lvl_i     (lvl[PIN_CONV]),
        .conv_rise_i    (rise[PIN_CONV]),
        .conv_fall_i    (fall[PIN_CONV]),
        .xfer_partial_i (partial),
        .start_o        (start),
        .load_o         (load),
        .in_shift_o     (in_shift),
        .converting_o   (converting_o),
        .sleep_o        (sleep_o),
        .err_o          (proto_err_o)
    );

    sadc_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .load_i     (load),
        .in_shift_i (in_shift),
        .sck_rise_i (rise[PIN_SCK]),
        .sck_fall_i (fall[PIN_SCK]),
        .sdi_lvl_i  (lvl[PIN_SDI]),
        .codes_i    (codes),
        .bit_o      (shift_bit),
        .partial_o  (partial)
    );

    assign sdo_oe_o = in_shift;
    assign sdo_o    = in_shift & shift_bit;

endmodule

// File: rtl/sadc_port_model_chk.sv
module sadc_port_model_chk #(
    parameter int CONV_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic sdo_oe_o,
    input logic converting_o,
    input logic sleep_o,
    input logic proto_err_o
);

    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= 0;
        else if (converting_o) run_q <= run_q + 1;
        else                   run_q <= 0;
    end

    // R3: a finished conversion lasted at least the interval
    a_r3_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(converting_o) |-> run_q >= CONV_CYCLES);

    // R2: phases are mutually exclusive
    a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({converting_o, sleep_o, sdo_oe_o}));

    // R4: enable only follows a conversion or sleep
    a_r4_enable_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> $past(converting_o || sleep_o));

    // R3: sleep is entered only from a conversion
    a_r3_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(converting_o));

    // R9: error is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);

    // R9: error rises only together with a conversion start
    a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err_o) |-> converting_o);

endmodule

bind sadc_port_model sadc_port_model_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sdo_oe_o     (sdo_oe_o),
    .converting_o (converting_o),
    .sleep_o      (sleep_o),
    .proto_err_o  (proto_err_o)
);

// File: tb/sadc_port_model_tb_top.sv
`timescale 1ns/1ps
module sadc_port_model_tb_top;

    localparam int CC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [11:0] c_se0 = 12'hA5C, c_se1 = 12'h3E1, c_d01 = 12'hFFF, c_d10 = 12'h801;
    logic sdo, oe, cv, slp, err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int cyc     = 0;

    always #2 clk = ~clk;

    sadc_port_model dut_i (
        .clk(clk), .rst_n(rst_n), .conv_i(conv), .sck_i(sck), .sdi_i(sdi),
        .code_se0_i(c_se0), .code_se1_i(c_se1), .code_d01_i(c_d01), .code_d10_i(c_d10),
        .sdo_o(sdo), .sdo_oe_o(oe), .converting_o(cv), .sleep_o(slp), .proto_err_o(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_state;            // 0 idle, 1 conv, 2 sleep, 3 shift
    int m_cnt, m_falls, m_rxn;
    bit m_err, m_rxb;
    logic [1:0]  m_next, m_act;
    logic [11:0] m_sh;
    logic [3:0]  hc, hs, hd;   // input history, [0] newest

    function automatic logic [11:0] pick(input logic [1:0] s);
        case (s)
            2'b10:   return c_se0;
            2'b11:   return c_se1;
            2'b00:   return c_d01;
            default: return c_d10;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_falls = 0; m_rxn = 0; m_err = 0; m_rxb = 0;
            m_next = 2'b10; m_act = 2'b10; m_sh = '0; hc = '0; hs = '0; hd = '0;
        end else begin
            bit cr, cf, sr, sf, cl, dl, do_start, do_load;
            hc = {hc[2:0], conv}; hs = {hs[2:0], sck}; hd = {hd[2:0], sdi};
            cl = hc[2]; dl = hd[2];
            cr = hc[2] & ~hc[3]; cf = ~hc[2] & hc[3];
            sr = hs[2] & ~hs[3]; sf = ~hs[2] & hs[3];
            do_start = 0; do_load = 0;
            if (cr) begin
                if (m_state == 1 || (m_state == 3 && m_falls > 0 && m_falls < 12)) m_err = 1;
                do_start = 1;
            end else begin
                case (m_state)
                    1: if (m_cnt == CC - 1) begin
                           if (cl) m_state = 2; else do_load = 1;
                       end else m_cnt++;
                    2: if (cf) do_load = 1;
                    3: begin
                        if (sf) begin
                            m_sh = {m_sh[10:0], 1'b0};
                            if (m_falls < 12) m_falls++;
                        end
                        if (sr && m_rxn < 2) begin
                            if (m_rxn == 0) m_rxb = dl; else m_next = {m_rxb, dl};
                            m_rxn++;
                        end
                    end
                    default: ;
                endcase
            end
            if (do_start) begin
                m_state = 1; m_cnt = 0; m_act = m_next; m_falls = 0;
            end
            if (do_load) begin
                m_state = 3; m_sh = pick(m_act); m_falls = 0; m_rxn = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 oe",         32'(oe),  32'(m_state == 3));
            chk("R5 sdo",        32'(sdo), 32'((m_state == 3) & m_sh[11]));
            chk("R3 converting", 32'(cv),  32'(m_state == 1));
            chk("R3 sleep",      32'(slp), 32'(m_state == 2));
            chk("R9 err",        32'(err), 32'(m_err));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sck();
        sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    endtask

    task automatic xfer(input int n, input logic [1:0] mw, output logic [15:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            sdi = (i == 0) ? mw[1] : (i == 1) ? mw[0] : ~mw[i & 1];
            tick(4);
            got = {got[14:0], sdo};
            sck = 1'b1; tick(4); sck = 1'b0;
        end
        tick(4);
    endtask

    task automatic read_cycle(input logic [1:0] mw, input logic [11:0] exp, input string tag);
        logic [15:0] g;
        conv = 1'b1; tick(CC + 6);
        conv = 1'b0; tick(6);
        xfer(12, mw, g);
        chk(tag, 32'(g[11:0]), 32'(exp));
    endtask

    initial begin
        logic [15:0] g;
        tick(5); rst_n = 1'b1; tick(2);
        // R1 reset state
        chk("R1 reset outputs", 32'({oe, sdo, cv, slp, err}), 32'h0);

        // first conversion with sleep and ignored shift pulses
        conv = 1'b1; tick(4);
        chk("R3 converting after rise", 32'(cv), 32'h1);
        tick(CC + 4);
        chk("R3 sleep with strobe high", 32'(slp), 32'h1);
        chk("R2 oe low in sleep", 32'(oe), 32'h0);
        pulse_sck(); pulse_sck(); pulse_sck();
        chk("R10 sdo quiet while disabled", 32'(sdo), 32'h0);
        conv = 1'b0; tick(6);
        chk("R4 oe after fall", 32'(oe), 32'h1);
        xfer(16, 2'b11, g);
        chk("R1 R8 R10 default pairing word", 32'(g[15:4]), 32'hA5C);
        chk("R6 zero tail", 32'(g[3:0]), 32'h0);

        read_cycle(2'b00, 12'h3E1, "R7 word 11 selects se1");
        tick(4);
        chk("R9 no error after full read", 32'(err), 32'h0);
        read_cycle(2'b01, 12'hFFF, "R8 word 00 full-scale d01");
        read_cycle(2'b10, 12'h801, "R8 word 01 selects d10");

        // early strobe fall: no sleep phase
        conv = 1'b1; tick(3); conv = 1'b0; tick(CC + 6);
        chk("R3 enable without sleep", 32'(oe), 32'h1);
        xfer(12, 2'b10, g);
        chk("R8 word 10 selects se0", 32'(g[11:0]), 32'hA5C);

        // rise with no bits read
        conv = 1'b1; tick(CC + 6); conv = 1'b0; tick(6);
        conv = 1'b1; tick(4);
        chk("R9 no error after empty read", 32'(err), 32'h0);
        // partial read
        tick(CC + 4); conv = 1'b0; tick(6);
        xfer(5, 2'b11, g);
        conv = 1'b1; tick(4);
        chk("R9 error after partial read", 32'(err), 32'h1);
        tick(CC + 4);

        // reset again, then rise inside the conversion interval
        conv = 1'b0; sck = 1'b0; sdi = 1'b0;
        rst_n = 1'b0; tick(3);
        chk("R1 reset clears error", 32'({oe, sdo, cv, slp, err}), 32'h0);
        rst_n = 1'b1; tick(2);
        conv = 1'b1; tick(5); conv = 1'b0; tick(3); conv = 1'b1; tick(4);
        chk("R9 error on rise during conversion", 32'(err), 32'h1);
        chk("R9 conversion restarted", 32'(cv), 32'h1);
        tick(CC + 4); conv = 1'b0; tick(6);
        xfer(12, 2'b10, g);
        chk("R1 mux word reset to se0", 32'(g[11:0]), 32'hA5C);

        tick(10);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule